// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the digital core of a two-wire serial memory slave with a 512-byte array held in registers. It brings SCL and SDA into the system clock domain, detects start and stop conditions and decodes the device-select byte and the word address. It then serves single-byte writes, page writes of up to 16 bytes, random reads, current-address reads and sequential reads. The slave acknowledges a byte by pulling SDA low through an open-drain style output.

Written bytes collect in a 16-entry page buffer. They reach the array only after the host ends the transfer with a stop, which starts a timed write cycle of a parameterised number of system clocks. While that cycle runs the slave ignores the bus completely, so the host can poll with the device-select byte until the slave acknowledges it. A running address counter serves current-address reads. A write-protect input keeps the array unchanged: bytes are still acknowledged, but the write cycle does not start.

Top module: `i2c_mem_slave`

## Requirements
- R1: A device-select byte is acknowledged only when its bits 7:4 equal 1010 and its bits 3:2 equal `hw_addr_i`. Bit 1 is word-address bit 8 and bit 0 is read (1) or write (0). After a mismatch the slave leaves SDA released until the next start.
- R2: A byte written to address A and committed can be read back at A with a random read (a write header, the word address, a repeated start, then a read header).
- R3: In a page write the low 4 address bits step and wrap within the 16-byte page while bits 8:4 stay fixed, so byte 17 overwrites byte 1. The address counter ends at the page base plus (start offset + count) mod 16.
- R4: A stop that ends a write with at least one data byte raises `busy_o` for exactly WR_CYCLES system clocks. The array is updated when `busy_o` falls.
- R5: While `busy_o` is high the slave acknowledges no byte, including its own device-select byte, and never pulls SDA low.
- R6: After an access to address N, a current-address read returns the byte at N+1. The counter uses all 9 bits and ignores the select byte's bit 1.
- R7: During a read, a master acknowledge moves on to the next address, wrapping from 511 to 0. A master no-acknowledge ends the read.
- R8: With `wp_i` high at the stop, data bytes are still acknowledged, but `busy_o` stays low and the array keeps its contents.
- R9: An accepted byte is acknowledged by `sda_drive_low_o` being high during the ninth SCL clock. The slave changes its SDA drive only while SCL is low.
- R10: After reset `sda_drive_low_o` and `busy_o` are low, the array holds zeros and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| hw_addr_i | input | 2 | Strapped slave address bits |
| wp_i | input | 1 | Write protect, high blocks array updates |
| sda_drive_low_o | output | 1 | High pulls SDA low |
| busy_o | output | 1 | Timed write cycle in progress |

## Verification
A wrong bit count or a wrong role state shows up within one byte time as a misplaced or missing acknowledge on SDA. A corrupt address counter or page base shows up only on the next read, as wrong data at a predictable address. A faulty write timer shows up on `busy_o` as a run length that differs from WR_CYCLES, and polling during the cycle exposes any acknowledge given while busy. The bench sweeps many addresses, page offsets that wrap and the top-of-array wrap, and computes every expected byte from its own model of the array.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int unsigned ADDR_W  = 9;   // 512 bytes, bit 8 carried in select byte
  localparam int unsigned PAGE_W  = 4;   // 16-byte page
  localparam logic [3:0]  DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_state_e;

  typedef enum logic [1:0] {
    RL_DEV,
    RL_ADDR,
    RL_DATA
  } byte_role_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [1:0] line_raw;
  logic [1:0] line_s;
  logic [1:0] line_d;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [DEPTH-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[DEPTH-2:0], line_raw[g]};
    end
    assign line_s[g] = pipe_q[DEPTH-2];
    assign line_d[g] = pipe_q[DEPTH-1];
  end

  assign sda_o      = line_s[0];
  assign scl_rise_o = line_s[1] & ~line_d[1];
  assign scl_fall_o = ~line_s[1] & line_d[1];
  assign start_o    = line_s[1] & line_d[1] & line_d[0] & ~line_s[0];
  assign stop_o     = line_s[1] & line_d[1] & ~line_d[0] & line_s[0];
endmodule

// File: rtl/i2c_page_store.sv
module i2c_page_store #(
  parameter int unsigned WR_CYCLES = 2000,
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned PAGE_W    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     buf_clr_i,
  input  logic                     buf_wr_i,
  input  logic [PAGE_W-1:0]        buf_idx_i,
  input  logic [7:0]               buf_data_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  output logic                     busy_o
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned PAGE_N = 1 << PAGE_W;
  localparam int unsigned TW     = $clog2(WR_CYCLES + 1);

  logic [7:0]               slot_q [PAGE_N];
  logic [PAGE_N-1:0]        valid_q;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic                     busy_q;
  logic [TW-1:0]            tmr_q;
  logic                     done;
  logic [7:0]               mem_q [DEPTH];

  assign done = busy_q && (tmr_q == TW'(WR_CYCLES - 1));

  for (genvar s = 0; s < PAGE_N; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[s]  <= '0;
        valid_q[s] <= 1'b0;
      end else if (buf_clr_i || done) begin
        valid_q[s] <= 1'b0;
      end else if (buf_wr_i && !busy_q && buf_idx_i == PAGE_W'(s)) begin
        slot_q[s]  <= buf_data_i;
        valid_q[s] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
      page_q <= '0;
    end else if (commit_i && !busy_q) begin
      busy_q <= 1'b1;
      tmr_q  <= '0;
      page_q <= page_i;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else      tmr_q  <= tmr_q + TW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (done) begin
      for (int i = 0; i < PAGE_N; i++) begin
        if (valid_q[i]) mem_q[{page_q, PAGE_W'(i)}] <= slot_q[i];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign busy_o    = busy_q;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] hw_addr_i,
  input  logic       wp_i,
  output logic       sda_drive_low_o,
  output logic       busy_o
);
  logic sda_s, scl_rise, scl_fall, start_c, stop_c;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_c),
    .stop_o    (stop_c)
  );

  bus_state_e        state_q;
  byte_role_e        role_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic              a8_q, rd_mode_q, wr_mode_q, got_data_q, mack_q, drv_q;
  logic              buf_clr_q, buf_wr_q, commit_q;
  logic [PAGE_W-1:0] buf_idx_q;
  logic [7:0]        buf_data_q;
  logic [7:0]        rd_data;
  logic              busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      role_q     <= RL_DEV;
      cnt_q      <= '0;
      sh_q       <= '0;
      addr_q     <= '0;
      a8_q       <= 1'b0;
      rd_mode_q  <= 1'b0;
      wr_mode_q  <= 1'b0;
      got_data_q <= 1'b0;
      mack_q     <= 1'b0;
      drv_q      <= 1'b0;
      buf_clr_q  <= 1'b0;
      buf_wr_q   <= 1'b0;
      commit_q   <= 1'b0;
      buf_idx_q  <= '0;
      buf_data_q <= '0;
    end else begin
      buf_clr_q <= 1'b0;
      buf_wr_q  <= 1'b0;
      commit_q  <= 1'b0;
      if (busy) begin
        state_q <= ST_IDLE;  // bus ignored during write cycle
        drv_q   <= 1'b0;
      end else if (start_c) begin
        state_q    <= ST_RX;
        role_q     <= RL_DEV;
        cnt_q      <= '0;
        drv_q      <= 1'b0;
        rd_mode_q  <= 1'b0;
        wr_mode_q  <= 1'b0;
        got_data_q <= 1'b0;
        buf_clr_q  <= 1'b1;
      end else if (stop_c) begin
        state_q    <= ST_IDLE;
        drv_q      <= 1'b0;
        wr_mode_q  <= 1'b0;
        got_data_q <= 1'b0;
        if (wr_mode_q && got_data_q && !wp_i) commit_q  <= 1'b1;
        else                                  buf_clr_q <= 1'b1;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_s};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              unique case (role_q)
                RL_DEV: begin
                  if (sh_q[7:4] == DEV_TYPE && sh_q[3:2] == hw_addr_i) begin
                    drv_q     <= 1'b1;
                    state_q   <= ST_RX_ACK;
                    rd_mode_q <= sh_q[0];
                    wr_mode_q <= ~sh_q[0];
                    a8_q      <= sh_q[1];
                    role_q    <= RL_ADDR;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                RL_ADDR: begin
                  addr_q  <= {a8_q, sh_q};
                  drv_q   <= 1'b1;
                  state_q <= ST_RX_ACK;
                  role_q  <= RL_DATA;
                end
                default: begin
                  buf_wr_q           <= 1'b1;
                  buf_idx_q          <= addr_q[PAGE_W-1:0];
                  buf_data_q         <= sh_q;
                  addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
                  got_data_q         <= 1'b1;
                  drv_q              <= 1'b1;
                  state_q            <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rd_mode_q) begin
                state_q <= ST_TX;
                sh_q    <= rd_data;
                drv_q   <= ~rd_data[7];
              end else begin
                state_q <= ST_RX;
                drv_q   <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == 4'd7) begin
                drv_q   <= 1'b0;
                state_q <= ST_TX_ACK;
                addr_q  <= addr_q + ADDR_W'(1);
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 4'd1;
                sh_q  <= {sh_q[6:0], 1'b0};
                drv_q <= ~sh_q[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                state_q <= ST_TX;
                sh_q    <= rd_data;
                drv_q   <= ~rd_data[7];
                cnt_q   <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  i2c_page_store #(
    .WR_CYCLES(WR_CYCLES),
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .buf_clr_i (buf_clr_q),
    .buf_wr_i  (buf_wr_q),
    .buf_idx_i (buf_idx_q),
    .buf_data_i(buf_data_q),
    .commit_i  (commit_q),
    .page_i    (addr_q[ADDR_W-1:PAGE_W]),
    .rd_addr_i (addr_q),
    .rd_data_o (rd_data),
    .busy_o    (busy)
  );

  assign sda_drive_low_o = drv_q;
  assign busy_o          = busy;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int unsigned WR_CYCLES = 2000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic wp_i,
  input logic busy_o,
  input logic sda_drive_low_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  p_busy_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < WR_CYCLES);

  p_busy_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == WR_CYCLES);

  p_quiet_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_drive_low_o);

  p_wp_no_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(wp_i));

  p_drive_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_drive_low_o) |-> !scl_i);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .scl_i          (scl_i),
  .wp_i           (wp_i),
  .busy_o         (busy_o),
  .sda_drive_low_o(sda_drive_low_o)
);

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  localparam int unsigned WR = 300;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_h = 1'b1;
  logic       wp = 1'b0;
  logic [1:0] hw = 2'b10;
  logic       sda_drv, busy;
  logic       sda_line;

  assign sda_line = sda_h & ~sda_drv;

  i2c_mem_slave #(.WR_CYCLES(WR)) dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .scl_i          (scl),
    .sda_i          (sda_line),
    .hw_addr_i      (hw),
    .wp_i           (wp),
    .sda_drive_low_o(sda_drv),
    .busy_o         (busy)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] model [512];
  int ctr = 0;
  int run = 0;
  int last_run = 0;

  always @(negedge clk) begin
    if (busy) run = run + 1;
    else if (run != 0) begin
      last_run = run;
      run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    end
    sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
    end
    tick(Q); sda_h = ~mack; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0;
    tick(Q); sda_h = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic a8, input logic rd);
    return {4'b1010, hw, a8, rd};
  endfunction

  function automatic logic [7:0] pdat(input int seed, input int i);
    return 8'((seed * 7 + i * 29 + 3) & 255);
  endfunction

  task automatic do_write(input int a, input int n, input int seed, input string req);
    logic ack;
    bus_start();
    send_byte(dev(a[8], 1'b0), ack);
    check(ack, "R9 dev ack", int'(ack), 1);
    send_byte(8'(a & 255), ack);
    check(ack, "R9 addr ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(pdat(seed, i), ack);
      check(ack, req, int'(ack), 1);
      if (!wp) model[(a & 496) | ((a + i) & 15)] = pdat(seed, i);
    end
    bus_stop();
    ctr = (a & 496) | ((a + n) & 15);
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(2);
  endtask

  // rnd=1: random read at a; rnd=0: current-address read
  task automatic do_read(input bit rnd, input int a, input int n, input string req);
    logic ack;
    logic [7:0] b;
    int base;
    base = rnd ? a : ctr;
    bus_start();
    if (rnd) begin
      send_byte(dev(a[8], 1'b0), ack);
      send_byte(8'(a & 255), ack);
      bus_start();
    end
    send_byte(dev(1'b0, 1'b1), ack);
    check(ack, "R9 read header ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      check(b == model[(base + i) % 512], req, int'(b), int'(model[(base + i) % 512]));
    end
    bus_stop();
    ctr = (base + n) % 512;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    int a;
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    tick(5);
    check(sda_drv == 1'b0, "R10 sda released in reset", int'(sda_drv), 0);
    check(busy == 1'b0, "R10 busy low in reset", int'(busy), 0);
    rst_n = 1'b1;
    tick(5);
    do_read(1'b0, 0, 1, "R10 counter starts at zero");

    // R1: wrong type code, wrong strap bits
    bus_start();
    send_byte({4'b1011, hw, 2'b00}, ack);
    check(!ack, "R1 wrong type code", int'(ack), 0);
    send_byte(8'h00, ack);
    check(!ack, "R1 ignored until start", int'(ack), 0);
    check(sda_drv == 1'b0, "R9 released after nack", int'(sda_drv), 0);
    bus_stop();
    bus_start();
    send_byte({4'b1010, ~hw, 2'b00}, ack);
    check(!ack, "R1 wrong strap bits", int'(ack), 0);
    bus_stop();

    // byte write sweep with polling
    for (int k = 0; k < 10; k++) begin
      a = (k * 53 + 7) % 512;
      do_write(a, 1, k, "R2 data ack");
      check(busy == 1'b1, "R4 busy after stop", int'(busy), 1);
      bus_start();
      send_byte(dev(1'b0, 1'b0), ack);
      check(!ack, "R5 no ack while busy", int'(ack), 0);
      bus_stop();
      wait_idle();
      check(last_run == WR, "R4 write cycle length", last_run, WR);
      do_read(1'b1, a, 1, "R2 readback");
      do_read(1'b0, 0, 1, "R6 current address");
    end

    // page write with wrap inside page
    do_write(163, 18, 99, "R3 page data ack");
    wait_idle();
    do_read(1'b0, 0, 1, "R3 counter after page wrap");
    do_read(1'b1, 160, 16, "R3 R7 page readback");
    do_read(1'b0, 0, 1, "R6 after sequential read");

    // top-of-array wrap
    do_write(511, 1, 5, "R7 setup");
    wait_idle();
    do_write(0, 1, 6, "R7 setup");
    wait_idle();
    do_read(1'b1, 510, 3, "R7 wrap 511 to 0");
    do_read(1'b0, 0, 2, "R6 R7 current after wrap");

    // write protect
    wp = 1'b1;
    do_write(291, 2, 77, "R8 ack under protect");
    tick(2);
    check(busy == 1'b0, "R8 no write cycle", int'(busy), 0);
    bus_start();
    send_byte(dev(1'b0, 1'b0), ack);
    check(ack, "R8 slave not busy", int'(ack), 1);
    bus_stop();
    wp = 1'b0;
    do_read(1'b1, 291, 2, "R8 array unchanged");

    // current read after committed write
    do_write(80, 1, 12, "R6 setup");
    wait_idle();
    do_read(1'b0, 0, 1, "R6 write then current read");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule